// File: doc/BRIEF.md
# Color LCD Controller Register Bank

This block is the slave register bank of a color LCD controller. It occupies a 4 KB window. A single-cycle bus with word addressing reaches it: one select cycle moves one 32-bit word. Write data commits at the clock edge that ends the cycle. Read data and the error flag are combinational during the select cycle.

The bank stores four panel timing words, two frame base addresses (upper and lower panel), a control word and an interrupt mask. It also keeps a raw interrupt status vector. Event pulses set the status bits, and software clears them by writing ones. From the stored words the bank decodes live values for downstream logic: the panel width in pixels, the panel height in lines, the pixel depth code and an enabled flag. A read-only identification window sits at the top of the space.

A strap input selects an alternate map, in which the mask word and the control word trade places. Palette storage, frame fetching and panel timing generation are outside this block. Any access the map does not allow reads as zero, has no effect and raises the error flag.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every stored word and all status bits are zero. As a result panel_cols = 16, panel_rows = 1, depth_code = 0, lcd_enabled = 0 and irq = 0.
- R2: Word addresses map as follows, each readable and writable: 0..3 timing words, 4 upper base, 5 lower base, 6 mask, 7 control. Word 8 reads the raw status and word 9 reads status AND mask; both are read-only. Word 10 is the write-only clear word.
- R3: While alt_map is 1, word 6 reaches the control word and word 7 reaches the mask, for both reads and writes.
- R4: panel_cols equals ((timing0 AND 0xFC) + 4) × 4 and follows every write of timing word 0.
- R5: panel_rows equals (timing1 AND 0x3FF) + 1 and follows every write of timing word 1.
- R6: depth_code equals control bits [3:1]. lcd_enabled is 1 only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R7: irq is 1 exactly when raw status AND mask is nonzero.
- R8: Writing word 10 clears each raw status bit whose data bit is 1. A 1 on irq_set[i] sets bit i at the next edge, even when a clear of that bit happens in the same cycle.
- R9: Reads of words 0x3F8..0x3FF return, in ascending order, the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R10: Word 11 reads the upper base and word 12 reads the lower base. Both are read-only.
- R11: A read of an unmapped word, of word 10, or of any word while bus_wr is 0 and nothing is mapped there returns 0. A write to an unmapped or read-only word (8, 9, 11, 12, the ID window) changes no state. In both cases bus_err is 1 during that select cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access cycle select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is 1 |
| bus_err | output | 1 | Access not allowed by the map |
| alt_map | input | 1 | Strap: swap mask and control word addresses |
| irq_set | input | NIRQ | Per-bit status set pulses |
| irq | output | 1 | Masked interrupt request |
| panel_cols | output | 11 | Decoded panel width in pixels |
| panel_rows | output | 11 | Decoded panel height in lines |
| depth_code | output | 3 | Pixel depth code |
| lcd_enabled | output | 1 | Enable and power both set |

## Verification
On every cycle the assertions check four things. A set pulse always lands in the status, and a clear removes every written bit that no pulse re-sets. The geometry outputs and the enabled flag only move after a write. A failed read returns zero. The bench scenarios cover the rest: the exact column and row arithmetic at field extremes, the swap of the two words under the strap, the identification bytes and their order, and the readback of every word against a model. They also show that writes to read-only or unmapped words leave all state untouched.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int WORD_AW  = 10;
  localparam int NTIM     = 4;
  localparam int COL_W    = 11;
  localparam int ROW_W    = 11;
  localparam int DEPTH_W  = 3;
  localparam int EN_BIT   = 0;
  localparam int PWR_BIT  = 11;
  localparam logic [WORD_AW-1:0] ID_WORD = 10'h3F8;

  typedef enum logic [3:0] {
    RG_NONE, RG_T0, RG_T1, RG_T2, RG_T3, RG_UPB, RG_LPB, RG_MASK,
    RG_CTRL, RG_RAW, RG_MIS, RG_CLR, RG_UPC, RG_LPC, RG_ID
  } lcdc_reg_e;

  // width in pixels: sixteen per step of the 6-bit field, plus one step
  function automatic logic [COL_W-1:0] cols_from_field(input logic [5:0] ppl);
    return COL_W'(({5'd0, ppl} + 11'd1) << 4);
  endfunction

  function automatic logic [ROW_W-1:0] rows_from_field(input logic [9:0] lpp);
    return {1'b0, lpp} + 11'd1;
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h10;
      3'd1: return 8'h11;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_regs_pkg::*;
(
  input  logic [WORD_AW-1:0] word,
  input  logic               alt_map,
  output lcdc_reg_e          reg_sel,
  output logic               rd_ok,
  output logic               wr_ok
);
  always_comb begin
    reg_sel = RG_NONE;
    if (word >= ID_WORD) begin
      reg_sel = RG_ID;
    end else begin
      case (word)
        10'd0:  reg_sel = RG_T0;
        10'd1:  reg_sel = RG_T1;
        10'd2:  reg_sel = RG_T2;
        10'd3:  reg_sel = RG_T3;
        10'd4:  reg_sel = RG_UPB;
        10'd5:  reg_sel = RG_LPB;
        10'd6:  reg_sel = alt_map ? RG_CTRL : RG_MASK;
        10'd7:  reg_sel = alt_map ? RG_MASK : RG_CTRL;
        10'd8:  reg_sel = RG_RAW;
        10'd9:  reg_sel = RG_MIS;
        10'd10: reg_sel = RG_CLR;
        10'd11: reg_sel = RG_UPC;
        10'd12: reg_sel = RG_LPC;
        default: reg_sel = RG_NONE;
      endcase
    end
  end

  always_comb begin
    rd_ok = (reg_sel != RG_NONE) && (reg_sel != RG_CLR);
    case (reg_sel)
      RG_T0, RG_T1, RG_T2, RG_T3, RG_UPB, RG_LPB,
      RG_MASK, RG_CTRL, RG_CLR: wr_ok = 1'b1;
      default:                  wr_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/lcdc_irq_unit.sv
module lcdc_irq_unit #(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_i,
  input  logic            clr_stb,
  input  logic [NIRQ-1:0] clr_bits,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw_o,
  output logic [NIRQ-1:0] mis_o,
  output logic            irq_o
);
  logic [NIRQ-1:0] raw_q;
  logic [NIRQ-1:0] clr_eff;

  assign clr_eff = clr_stb ? clr_bits : '0;

  // set after clear: a pulse wins over a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_eff) | set_i;
  end

  assign raw_o = raw_q;
  assign mis_o = raw_q & mask;
  assign irq_o = |mis_o;
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_regs_pkg::*;
(
  input  logic [5:0]         ppl_field,
  input  logic [9:0]         lpp_field,
  input  logic [DEPTH_W-1:0] depth_field,
  input  logic               en_bit,
  input  logic               pwr_bit,
  output logic [COL_W-1:0]   cols,
  output logic [ROW_W-1:0]   rows,
  output logic [DEPTH_W-1:0] depth,
  output logic               enabled
);
  assign cols    = cols_from_field(ppl_field);
  assign rows    = rows_from_field(lpp_field);
  assign depth   = depth_field;
  assign enabled = en_bit & pwr_bit;
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_regs_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [WORD_AW-1:0]     bus_waddr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_err,
  input  logic                   alt_map,
  input  logic [NIRQ-1:0]        irq_set,
  output logic                   irq,
  output logic [COL_W-1:0]       panel_cols,
  output logic [ROW_W-1:0]       panel_rows,
  output logic [DEPTH_W-1:0]     depth_code,
  output logic                   lcd_enabled
);
  lcdc_reg_e         reg_sel;
  logic              rd_ok, wr_ok, wr_stb, clr_stb;
  logic [NTIM-1:0]   tim_we;
  logic [DATA_W-1:0] tim_q [NTIM];
  logic [DATA_W-1:0] upb_q, lpb_q, ctrl_q;
  logic [NIRQ-1:0]   mask_q, raw_stat, mis_stat;

  lcdc_addr_dec u_dec (
    .word    (bus_waddr),
    .alt_map (alt_map),
    .reg_sel (reg_sel),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok)
  );

  assign wr_stb  = bus_sel && bus_wr && wr_ok;
  assign clr_stb = wr_stb && (reg_sel == RG_CLR);
  assign bus_err = bus_sel && (bus_wr ? !wr_ok : !rd_ok);

  always_comb begin
    tim_we = '0;
    case (reg_sel)
      RG_T0: tim_we[0] = wr_stb;
      RG_T1: tim_we[1] = wr_stb;
      RG_T2: tim_we[2] = wr_stb;
      RG_T3: tim_we[3] = wr_stb;
      default: tim_we = '0;
    endcase
  end

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tim_q[g] <= '0;
      else if (tim_we[g]) tim_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_stb) begin
      case (reg_sel)
        RG_UPB:  upb_q  <= bus_wdata;
        RG_LPB:  lpb_q  <= bus_wdata;
        RG_CTRL: ctrl_q <= bus_wdata;
        RG_MASK: mask_q <= bus_wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  lcdc_irq_unit #(.NIRQ(NIRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (irq_set),
    .clr_stb  (clr_stb),
    .clr_bits (bus_wdata[NIRQ-1:0]),
    .mask     (mask_q),
    .raw_o    (raw_stat),
    .mis_o    (mis_stat),
    .irq_o    (irq)
  );

  lcdc_geom u_geom (
    .ppl_field   (tim_q[0][7:2]),
    .lpp_field   (tim_q[1][9:0]),
    .depth_field (ctrl_q[DEPTH_W:1]),
    .en_bit      (ctrl_q[EN_BIT]),
    .pwr_bit     (ctrl_q[PWR_BIT]),
    .cols        (panel_cols),
    .rows        (panel_rows),
    .depth       (depth_code),
    .enabled     (lcd_enabled)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (reg_sel)
        RG_T0:   bus_rdata = tim_q[0];
        RG_T1:   bus_rdata = tim_q[1];
        RG_T2:   bus_rdata = tim_q[2];
        RG_T3:   bus_rdata = tim_q[3];
        RG_UPB,
        RG_UPC:  bus_rdata = upb_q;
        RG_LPB,
        RG_LPC:  bus_rdata = lpb_q;
        RG_MASK: bus_rdata = DATA_W'(mask_q);
        RG_CTRL: bus_rdata = ctrl_q;
        RG_RAW:  bus_rdata = DATA_W'(raw_stat);
        RG_MIS:  bus_rdata = DATA_W'(mis_stat);
        RG_ID:   bus_rdata = DATA_W'(id_byte(bus_waddr[2:0]));
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic            bus_err,
  input logic [31:0]     bus_rdata,
  input logic [31:0]     bus_wdata,
  input logic [NIRQ-1:0] irq_set,
  input logic [NIRQ-1:0] raw_stat,
  input logic            clr_stb,
  input logic            irq,
  input logic [10:0]     panel_cols,
  input logic [10:0]     panel_rows,
  input logic            lcd_enabled
);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((raw_stat & $past(irq_set)) == $past(irq_set)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((raw_stat & $past(bus_wdata[NIRQ-1:0]) & ~$past(irq_set)) == '0));

  p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|raw_stat));

  // covers R5 as well: rows hold alongside cols
  p_geom_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(panel_cols) && $stable(panel_rows)));

  p_enable_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_enabled) |-> $past(bus_sel && bus_wr));

  p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_err) |-> (bus_rdata == '0));
endmodule

bind lcdc_regbank lcdc_regbank_chk #(.NIRQ(NIRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_err     (bus_err),
  .bus_rdata   (bus_rdata),
  .bus_wdata   (bus_wdata),
  .irq_set     (irq_set),
  .raw_stat    (raw_stat),
  .clr_stb     (clr_stb),
  .irq         (irq),
  .panel_cols  (panel_cols),
  .panel_rows  (panel_rows),
  .lcd_enabled (lcd_enabled)
);

// File: tb/lcdc_regbank_bench.sv
`timescale 1ns/1ps
module lcdc_regbank_bench;
  localparam int NIRQ = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, alt_map = 1'b0, irq;
  logic [NIRQ-1:0] irq_set = '0;
  logic [10:0] panel_cols, panel_rows;
  logic [2:0]  depth_code;
  logic        lcd_enabled;

  lcdc_regbank #(.NIRQ(NIRQ)) u_lcdc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .alt_map(alt_map), .irq_set(irq_set), .irq(irq),
    .panel_cols(panel_cols), .panel_rows(panel_rows),
    .depth_code(depth_code), .lcd_enabled(lcd_enabled)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_t [4];
  logic [31:0] m_up, m_lp, m_ctrl;
  logic [NIRQ-1:0] m_mask, m_raw;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int logical_word(logic [9:0] w);
    if (alt_map && w == 10'd6) return 7;
    if (alt_map && w == 10'd7) return 6;
    return int'(w);
  endfunction

  function automatic bit in_id(logic [9:0] w);
    return w >= 10'h3F8;
  endfunction

  function automatic logic [31:0] id_ref(logic [9:0] w);
    logic [7:0] tbl [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'd0, tbl[w - 10'h3F8]};
  endfunction

  function automatic bit rd_bad(logic [9:0] w);
    int lw = logical_word(w);
    if (in_id(w)) return 0;
    return !((lw >= 0 && lw <= 9) || lw == 11 || lw == 12);
  endfunction

  function automatic bit wr_bad(logic [9:0] w);
    int lw = logical_word(w);
    if (in_id(w)) return 1;
    return !((lw >= 0 && lw <= 7) || lw == 10);
  endfunction

  function automatic logic [31:0] rd_ref(logic [9:0] w);
    if (in_id(w)) return id_ref(w);
    case (logical_word(w))
      0: return m_t[0];
      1: return m_t[1];
      2: return m_t[2];
      3: return m_t[3];
      4, 11: return m_up;
      5, 12: return m_lp;
      6: return {28'd0, m_mask};
      7: return m_ctrl;
      8: return {28'd0, m_raw};
      9: return {28'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outs(string tag);
    chk({tag, " R4 cols"}, {21'd0, panel_cols}, ((m_t[0] & 32'hFC) + 32'd4) * 32'd4);
    chk({tag, " R5 rows"}, {21'd0, panel_rows}, (m_t[1] & 32'h3FF) + 32'd1);
    chk({tag, " R6 depth"}, {29'd0, depth_code}, (m_ctrl >> 1) & 32'h7);
    chk({tag, " R6 enabled"}, {31'd0, lcd_enabled}, {31'd0, m_ctrl[0] && m_ctrl[11]});
    chk({tag, " R7 irq"}, {31'd0, irq}, {31'd0, (m_raw & m_mask) != 0});
  endtask

  task automatic do_write(logic [9:0] w, logic [31:0] d, logic [NIRQ-1:0] setb, string tag);
    int lw = logical_word(w);
    bit bad = wr_bad(w);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_waddr = w; bus_wdata = d; irq_set = setb;
    #1 chk({tag, " R11 write err"}, {31'd0, bus_err}, {31'd0, bad});
    @(posedge clk);
    if (!bad) begin
      case (lw)
        0, 1, 2, 3: m_t[lw] = d;
        4: m_up = d;
        5: m_lp = d;
        6: m_mask = d[NIRQ-1:0];
        7: m_ctrl = d;
        10: m_raw = m_raw & ~d[NIRQ-1:0];
        default: ;
      endcase
    end
    m_raw = m_raw | setb;
    #1 bus_sel = 0; bus_wr = 0; irq_set = '0;
  endtask

  task automatic do_read(logic [9:0] w, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_waddr = w;
    #1 chk({tag, " read data"}, bus_rdata, rd_ref(w));
    chk({tag, " R11 read err"}, {31'd0, bus_err}, {31'd0, rd_bad(w)});
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 4; i++) m_t[i] = '0;
    m_up = '0; m_lp = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    check_outs("R1 reset");
    chk("R1 cols 16", {21'd0, panel_cols}, 32'd16);
    chk("R1 rows 1", {21'd0, panel_rows}, 32'd1);
    for (int w = 0; w < 13; w++) do_read(10'(w), "R1 R2 R10 reset readback");

    // R9: identification bytes
    for (int w = 10'h3F8; w <= 10'h3FF; w++) do_read(10'(w), "R9 id");

    // R4/R5 extremes
    do_write(10'd0, 32'h0000_00FC, '0, "R4"); check_outs("R4 max");
    chk("R4 cols 1024", {21'd0, panel_cols}, 32'd1024);
    do_write(10'd0, 32'hFFFF_FF03, '0, "R4"); check_outs("R4 low bits ignored");
    chk("R4 cols 16", {21'd0, panel_cols}, 32'd16);
    do_write(10'd1, 32'h0000_03FF, '0, "R5"); check_outs("R5 max");
    chk("R5 rows 1024", {21'd0, panel_rows}, 32'd1024);
    do_write(10'd1, 32'hFFFF_FC00, '0, "R5"); check_outs("R5 min");

    // R6: enable needs power too
    do_write(10'd7, 32'h0000_0001, '0, "R6"); check_outs("R6 enable only");
    do_write(10'd7, 32'h0000_0800, '0, "R6"); check_outs("R6 power only");
    do_write(10'd7, 32'h0000_080B, '0, "R6"); check_outs("R6 both");
    chk("R6 enabled set", {31'd0, lcd_enabled}, 32'd1);

    // R3: alternate map swap
    alt_map = 1;
    do_write(10'd6, 32'h0000_000C, '0, "R3 ctrl via 6"); check_outs("R3");
    do_write(10'd7, 32'h0000_0005, '0, "R3 mask via 7");
    do_read(10'd6, "R3 ctrl read"); do_read(10'd7, "R3 mask read");
    alt_map = 0;
    do_read(10'd6, "R3 mask normal"); do_read(10'd7, "R3 ctrl normal");

    // R7/R8 interrupts
    do_write(10'd6, 32'hF, '0, "R7 mask");
    do_write(10'd4, 32'h1234_5678, 4'b0101, "R8 set"); check_outs("R7 after set");
    do_read(10'd8, "R8 raw"); do_read(10'd9, "R7 masked");
    do_write(10'd10, 32'h1, '0, "R8 clear"); do_read(10'd8, "R8 after clear");
    do_write(10'd10, 32'hF, 4'b0100, "R8 set wins"); do_read(10'd8, "R8 set beats clear");
    do_write(10'd6, 32'h0, '0, "R7 unmask"); check_outs("R7 masked off");

    // R10 and R11
    do_write(10'd5, 32'hCAFE_0001, '0, "R10");
    do_read(10'd11, "R10 upper current"); do_read(10'd12, "R10 lower current");
    do_write(10'd11, 32'hFFFF_FFFF, '0, "R11 ro write");
    do_write(10'd8, 32'hFFFF_FFFF, '0, "R11 ro status write");
    do_write(10'h3F9, 32'hFFFF_FFFF, '0, "R11 id write");
    do_write(10'd13, 32'hFFFF_FFFF, '0, "R11 unmapped write");
    for (int w = 0; w < 13; w++) do_read(10'(w), "R11 state untouched");
    do_read(10'd10, "R11 clear word read"); do_read(10'h080, "R11 gap read");
    do_read(10'd13, "R11 unmapped read");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      logic [9:0] w;
      int r = int'($urandom % 16);
      if (it % 60 == 59) alt_map = ~alt_map;
      if (r < 13)       w = 10'(r);
      else if (r == 13) w = 10'h080 + 10'($urandom % 128);
      else if (r == 14) w = 10'h3F8 + 10'($urandom % 8);
      else              w = 10'd13 + 10'($urandom % 100);
      if ($urandom % 2 == 0)
        do_write(w, $urandom, ($urandom % 4 == 0) ? NIRQ'($urandom) : '0, "R2 rand");
      else
        do_read(w, "R2 rand");
      check_outs("rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule